// File: doc/BRIEF.md
# Test Access Port Controller with Instruction Decode

This block is the serial test port of a device. A sixteen-state controller follows the test-mode-select input on each rising test-clock edge. It steers serial data through one of three paths: a 10-bit instruction register, a 1-bit bypass stage, or a 32-bit identification register. The identification register loads either a fixed device code or a 32-bit user code taken from an input port. A fourth path is an external boundary chain. The block does not contain that chain. It drives the chain through capture, shift and update strobes, and through two static controls: pin test mode and all-pins-tristate.

A tester moves the controller with TMS and shifts an instruction in, least significant bit first. It then shifts data through whichever register that instruction selects. Serial input is sampled on the rising edge. Serial output and its enable change only on the falling edge, and the output is enabled only while the controller sits in one of the two shift states. The chain takes its serial input straight from TDI and returns its last bit on `chain_so`.

Top module: `tap_ctrl`

## Requirements
- R1: The controller powers up in test-logic-reset. Five consecutive clocks with TMS high bring it there from any state, and it stays there while TMS stays high. Four TMS-high clocks from shift-DR followed by TMS 0,0 land in shift-IR instead.
- R2: The states and TMS transitions are the standard sixteen-state ones. From reset, the TMS sequence 0,1,1,0,0 reaches shift-IR.
- R3: `tdo_en` is high only after a falling edge that falls inside shift-IR or shift-DR. It rises at the first falling edge after entering a shift state and drops at the first falling edge after leaving it.
- R4: Capture-IR loads the pattern 10'b0101010101, so the first bit shifted out is 1 and the bits alternate after that. The instruction is shifted in and out least significant bit first.
- R5: A newly shifted instruction takes effect at the falling edge in update-IR. In exit1-IR the previous instruction still drives the outputs. Entering reset loads IDCODE (10'h006).
- R6: Opcode 10'h3FF (all ones) and any opcode not listed in these requirements select the bypass stage. It captures 0, and a bit sampled on a rising edge leaves TDO at the falling edge of the same clock pulse.
- R7: IDCODE (10'h006) captures the fixed 32-bit device code (default 32'h1A5C_E0B3) and shifts it out LSB first.
- R8: USERCODE (10'h007) captures the value on `user_code` in parallel at capture-DR and shifts it out LSB first.
- R9: SAMPLE (10'h005) and EXTEST (10'h00F) route the external chain between TDI and TDO. `chain_capture`, `chain_shift` and `chain_update` are high in capture-DR, shift-DR and update-DR respectively, and at most one of them is high at a time. `chain_mode` is high under EXTEST and low under SAMPLE.
- R10: CLAMP (10'h00A) sets `chain_mode` high, keeps `chain_hiz` low and selects the bypass stage. The chain strobes stay low.
- R11: HIGHZ (10'h00B) sets `chain_hiz` high and selects the bypass stage. `chain_hiz` stays high across DR scans until another instruction is loaded, and the chain strobes stay low.
- R12: In test-logic-reset, `chain_mode` and `chain_hiz` are low (normal operation).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| tms | input | 1 | Test mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge; also feeds the external chain |
| tdo | output | 1 | Serial data out, changes on the falling edge |
| tdo_en | output | 1 | Output enable for tdo, high only while shifting |
| user_code | input | 32 | User code loaded by the USERCODE instruction |
| chain_so | input | 1 | Serial return from the last cell of the external chain |
| chain_capture | output | 1 | Chain capture strobe (capture-DR, chain selected) |
| chain_shift | output | 1 | Chain shift strobe (shift-DR, chain selected) |
| chain_update | output | 1 | Chain update strobe (update-DR, chain selected) |
| chain_mode | output | 1 | Pins driven from chain update cells |
| chain_hiz | output | 1 | All chain-controlled pins tristated |

## Verification
The embedded assertions check the following on every clock:
- the five-high return to reset and the reset hold;
- the key shift-state transitions;
- agreement between `tdo_en` and the shift states;
- the one-hot chain strobes;
- that the held instruction moves only at update-IR or reset;
- the normal-mode outputs in reset.

Some behaviour only the directed scenarios can show:
- the bit order of captured patterns and codes as seen at TDO;
- the half-cycle delay of a new instruction;
- the same-pulse bypass latency;
- the return of the user code;
- the fact that CLAMP and HIGHZ leave the external chain untouched during scans.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  typedef enum logic [3:0] {
    ST_TLR    = 4'h0,
    ST_RTI    = 4'h1,
    ST_SEL_DR = 4'h2,
    ST_CAP_DR = 4'h3,
    ST_SH_DR  = 4'h4,
    ST_EX1_DR = 4'h5,
    ST_PA_DR  = 4'h6,
    ST_EX2_DR = 4'h7,
    ST_UP_DR  = 4'h8,
    ST_SEL_IR = 4'h9,
    ST_CAP_IR = 4'hA,
    ST_SH_IR  = 4'hB,
    ST_EX1_IR = 4'hC,
    ST_PA_IR  = 4'hD,
    ST_EX2_IR = 4'hE,
    ST_UP_IR  = 4'hF
  } tap_state_t;

  typedef enum logic [1:0] {
    PATH_BYP   = 2'd0,
    PATH_ID    = 2'd1,
    PATH_CHAIN = 2'd2
  } dr_path_t;

  // Next controller state for the TMS value sampled on a rising edge
  function automatic tap_state_t tap_next(input tap_state_t s, input logic m);
    case (s)
      ST_TLR:    tap_next = m ? ST_TLR    : ST_RTI;
      ST_RTI:    tap_next = m ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: tap_next = m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: tap_next = m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  tap_next = m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: tap_next = m ? ST_UP_DR  : ST_PA_DR;
      ST_PA_DR:  tap_next = m ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: tap_next = m ? ST_UP_DR  : ST_SH_DR;
      ST_UP_DR:  tap_next = m ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: tap_next = m ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: tap_next = m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  tap_next = m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: tap_next = m ? ST_UP_IR  : ST_PA_IR;
      ST_PA_IR:  tap_next = m ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: tap_next = m ? ST_UP_IR  : ST_SH_IR;
      ST_UP_IR:  tap_next = m ? ST_SEL_DR : ST_RTI;
      default:   tap_next = ST_TLR;
    endcase
  endfunction

  function automatic logic is_shift(input tap_state_t s);
    is_shift = (s == ST_SH_IR) || (s == ST_SH_DR);
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       tms,
  output tap_state_t state,
  output logic       alive
);

  // Encoding puts reset at zero so that a zero power-up value is test-logic-reset
  always_ff @(posedge tck) begin
    state <= tap_next(state, tms);
    alive <= 1'b1;
  end

  // Checker: run length of consecutive TMS-high clocks, saturating at 5
  logic [2:0] high_run;
  always_ff @(posedge tck) begin
    if (!tms)                 high_run <= 3'd0;
    else if (high_run != 3'd5) high_run <= high_run + 3'd1;
  end

  assert_five_high_R1: assert property (@(posedge tck) disable iff (!alive)
    (high_run >= 3'd4 && tms) |=> state == ST_TLR);

  assert_tlr_hold_R1: assert property (@(posedge tck) disable iff (!alive)
    (state == ST_TLR && tms) |=> state == ST_TLR);

  assert_enter_shift_ir_R2: assert property (@(posedge tck) disable iff (!alive)
    (state == ST_CAP_IR && !tms) |=> state == ST_SH_IR);

  assert_leave_shift_dr_R2: assert property (@(posedge tck) disable iff (!alive)
    (state == ST_SH_DR && tms) |=> state == ST_EX1_DR);

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import scan_tap_pkg::*;
#(
  parameter int             IR_W        = 10,
  parameter logic [IR_W-1:0] OP_EXTEST   = 10'h00F,
  parameter logic [IR_W-1:0] OP_SAMPLE   = 10'h005,
  parameter logic [IR_W-1:0] OP_IDCODE   = 10'h006,
  parameter logic [IR_W-1:0] OP_USERCODE = 10'h007,
  parameter logic [IR_W-1:0] OP_CLAMP    = 10'h00A,
  parameter logic [IR_W-1:0] OP_HIGHZ    = 10'h00B
) (
  input  logic       tck,
  input  logic       tdi,
  input  tap_state_t state,
  input  logic       alive,
  output logic       ir_so,
  output dr_path_t   path,
  output logic       use_user,
  output logic       chain_mode,
  output logic       chain_hiz
);

  // Alternating capture pattern, bit 0 set
  function automatic logic [IR_W-1:0] alt_pattern();
    logic [IR_W-1:0] r;
    for (int i = 0; i < IR_W; i++) r[i] = ((i % 2) == 0);
    return r;
  endfunction

  localparam logic [IR_W-1:0] CAP_PAT = alt_pattern();

  logic [IR_W-1:0] ir_sr;
  logic [IR_W-1:0] ir_q;

  always_ff @(posedge tck) begin
    if (state == ST_CAP_IR)     ir_sr <= CAP_PAT;
    else if (state == ST_SH_IR) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
  end

  // Held instruction moves on the falling edge only
  always_ff @(negedge tck) begin
    if (state == ST_TLR)       ir_q <= OP_IDCODE;
    else if (state == ST_UP_IR) ir_q <= ir_sr;
  end

  assign ir_so = ir_sr[0];

  // Anything unlisted (including all ones) falls to bypass
  always_comb begin
    path       = PATH_BYP;
    use_user   = 1'b0;
    chain_mode = 1'b0;
    chain_hiz  = 1'b0;
    if (ir_q == OP_IDCODE) begin
      path = PATH_ID;
    end else if (ir_q == OP_USERCODE) begin
      path     = PATH_ID;
      use_user = 1'b1;
    end else if (ir_q == OP_EXTEST) begin
      path       = PATH_CHAIN;
      chain_mode = 1'b1;
    end else if (ir_q == OP_SAMPLE) begin
      path = PATH_CHAIN;
    end else if (ir_q == OP_CLAMP) begin
      chain_mode = 1'b1;
    end else if (ir_q == OP_HIGHZ) begin
      chain_hiz = 1'b1;
    end
  end

  assert_capture_pattern_R4: assert property (@(posedge tck) disable iff (!alive)
    (state == ST_CAP_IR) |=> ir_sr == CAP_PAT);

  assert_ir_stable_R5: assert property (@(posedge tck) disable iff (!alive)
    (state != ST_UP_IR && state != ST_TLR) |-> $stable(ir_q));

endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import scan_tap_pkg::*;
#(
  parameter int             ID_W   = 32,
  parameter logic [ID_W-1:0] DEV_ID = 32'h1A5C_E0B3
) (
  input  logic            tck,
  input  logic            tdi,
  input  tap_state_t      state,
  input  logic            alive,
  input  dr_path_t        path,
  input  logic            use_user,
  input  logic [ID_W-1:0] user_code,
  output logic            byp_so,
  output logic            id_so
);

  logic            byp_q;
  logic [ID_W-1:0] id_sr;

  always_ff @(posedge tck) begin
    if (state == ST_CAP_DR)                          byp_q <= 1'b0;
    else if (state == ST_SH_DR && path == PATH_BYP) byp_q <= tdi;
  end

  always_ff @(posedge tck) begin
    if (path == PATH_ID) begin
      if (state == ST_CAP_DR)     id_sr <= use_user ? user_code : DEV_ID;
      else if (state == ST_SH_DR) id_sr <= {tdi, id_sr[ID_W-1:1]};
    end
  end

  assign byp_so = byp_q;
  assign id_so  = id_sr[0];

  assert_bypass_follow_R6: assert property (@(posedge tck) disable iff (!alive)
    (state == ST_SH_DR && path == PATH_BYP) |=> byp_q == $past(tdi));

  assert_devid_capture_R7: assert property (@(posedge tck) disable iff (!alive)
    (state == ST_CAP_DR && path == PATH_ID && !use_user) |=> id_sr == DEV_ID);

endmodule

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import scan_tap_pkg::*;
#(
  parameter int             IR_W        = 10,
  parameter int             ID_W        = 32,
  parameter logic [ID_W-1:0] DEV_ID      = 32'h1A5C_E0B3,
  parameter logic [IR_W-1:0] OP_EXTEST   = 10'h00F,
  parameter logic [IR_W-1:0] OP_SAMPLE   = 10'h005,
  parameter logic [IR_W-1:0] OP_IDCODE   = 10'h006,
  parameter logic [IR_W-1:0] OP_USERCODE = 10'h007,
  parameter logic [IR_W-1:0] OP_CLAMP    = 10'h00A,
  parameter logic [IR_W-1:0] OP_HIGHZ    = 10'h00B
) (
  input  logic            tck,
  input  logic            tms,
  input  logic            tdi,
  output logic            tdo,
  output logic            tdo_en,
  input  logic [ID_W-1:0] user_code,
  input  logic            chain_so,
  output logic            chain_capture,
  output logic            chain_shift,
  output logic            chain_update,
  output logic            chain_mode,
  output logic            chain_hiz
);

  tap_state_t state;
  logic       alive;
  logic       ir_so, byp_so, id_so, use_user;
  dr_path_t   path;
  logic       dr_bit;

  tap_fsm u_fsm (.tck(tck), .tms(tms), .state(state), .alive(alive));

  tap_ir #(
    .IR_W(IR_W), .OP_EXTEST(OP_EXTEST), .OP_SAMPLE(OP_SAMPLE),
    .OP_IDCODE(OP_IDCODE), .OP_USERCODE(OP_USERCODE),
    .OP_CLAMP(OP_CLAMP), .OP_HIGHZ(OP_HIGHZ)
  ) u_ir (
    .tck(tck), .tdi(tdi), .state(state), .alive(alive), .ir_so(ir_so),
    .path(path), .use_user(use_user), .chain_mode(chain_mode),
    .chain_hiz(chain_hiz)
  );

  tap_dr #(.ID_W(ID_W), .DEV_ID(DEV_ID)) u_dr (
    .tck(tck), .tdi(tdi), .state(state), .alive(alive), .path(path),
    .use_user(use_user), .user_code(user_code), .byp_so(byp_so),
    .id_so(id_so)
  );

  always_comb begin
    case (path)
      PATH_ID:    dr_bit = id_so;
      PATH_CHAIN: dr_bit = chain_so;
      default:    dr_bit = byp_so;
    endcase
  end

  // Serial output and its enable move on the falling edge only
  always_ff @(negedge tck) begin
    tdo_en <= is_shift(state);
    if (state == ST_SH_IR)      tdo <= ir_so;
    else if (state == ST_SH_DR) tdo <= dr_bit;
    else                        tdo <= 1'b0;
  end

  assign chain_capture = (state == ST_CAP_DR) && (path == PATH_CHAIN);
  assign chain_shift   = (state == ST_SH_DR)  && (path == PATH_CHAIN);
  assign chain_update  = (state == ST_UP_DR)  && (path == PATH_CHAIN);

  assert_tdo_en_R3: assert property (@(posedge tck) disable iff (!alive)
    tdo_en == is_shift(state));

  assert_strobe_onehot_R9: assert property (@(posedge tck) disable iff (!alive)
    $onehot0({chain_capture, chain_shift, chain_update}));

  assert_hiz_no_strobe_R11: assert property (@(posedge tck) disable iff (!alive)
    chain_hiz |-> !(chain_capture || chain_shift || chain_update));

  assert_normal_in_reset_R12: assert property (@(posedge tck) disable iff (!alive)
    (state == ST_TLR && $past(state) == ST_TLR) |-> (!chain_mode && !chain_hiz));

endmodule

// File: tb/sim_tap_ctrl.sv
module sim_tap_ctrl;

  localparam logic [9:0]  C_EXTEST = 10'h00F;
  localparam logic [9:0]  C_SAMPLE = 10'h005;
  localparam logic [9:0]  C_USER   = 10'h007;
  localparam logic [9:0]  C_CLAMP  = 10'h00A;
  localparam logic [9:0]  C_HIGHZ  = 10'h00B;
  localparam logic [9:0]  C_ONES   = 10'h3FF;
  localparam logic [9:0]  C_ODD    = 10'h2A5;
  localparam logic [31:0] C_DEVID  = 32'h1A5C_E0B3;
  localparam logic [7:0]  CHAIN_CAP = 8'hC3;

  logic tck = 1'b0;
  logic tms = 1'b1, tdi = 1'b0;
  logic [31:0] user_code = 32'h0;
  logic tdo, tdo_en, chain_so, chain_capture, chain_shift, chain_update;
  logic chain_mode, chain_hiz;

  always #10 tck = ~tck;

  tap_ctrl u0 (
    .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .user_code(user_code), .chain_so(chain_so),
    .chain_capture(chain_capture), .chain_shift(chain_shift),
    .chain_update(chain_update), .chain_mode(chain_mode),
    .chain_hiz(chain_hiz)
  );

  // Bench model of an 8-cell boundary chain
  logic [7:0] chain = 8'h00;
  int cap_cnt = 0, upd_cnt = 0, sh_cnt = 0;
  assign chain_so = chain[0];
  always @(posedge tck) begin
    if (chain_capture) begin chain <= CHAIN_CAP; cap_cnt <= cap_cnt + 1; end
    else if (chain_shift) begin chain <= {tdi, chain[7:1]}; sh_cnt <= sh_cnt + 1; end
    if (chain_update) upd_cnt <= upd_cnt + 1;
  end

  int checks = 0, errors = 0;
  logic o_tdo, o_en;
  logic [9:0]  ir_cap;
  logic        en_first, en_all, en_exit, mode_exit, mode_upd, hiz_upd;
  logic [31:0] dr_out;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive TMS/TDI mid-low, let one rising and one falling edge pass, sample
  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck);
    @(negedge tck);
    #2;
    o_tdo = tdo; o_en = tdo_en;
  endtask

  task automatic reset_tap();
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  // From run-test/idle: load an instruction, return to idle
  task automatic load_ir(input logic [9:0] op);
    step(1, 0); step(1, 0); step(0, 0);
    step(0, 0);
    ir_cap[0] = o_tdo; en_first = o_en; en_all = 1'b1;
    for (int i = 0; i < 10; i++) begin
      step(i == 9, op[i]);
      if (i < 9) begin ir_cap[i+1] = o_tdo; en_all &= o_en; end
      else begin en_exit = o_en; mode_exit = chain_mode; end
    end
    step(1, 0);
    mode_upd = chain_mode; hiz_upd = chain_hiz;
    step(0, 0);
  endtask

  // From run-test/idle: scan n DR bits, return to idle
  task automatic scan_dr(input int n, input logic [31:0] din);
    dr_out = '0;
    step(1, 0); step(0, 0);
    step(0, 0);
    dr_out[0] = o_tdo;
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i]);
      if (i < n - 1) dr_out[i+1] = o_tdo;
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic t_reset_state();
    reset_tap();
    chk(o_en == 0, "R3 tdo_en idle after reset", 32'(o_en), 0);
    chk(chain_mode == 0 && chain_hiz == 0, "R12 normal operation after reset",
        {30'd0, chain_mode, chain_hiz}, 0);
    scan_dr(32, 32'h0);
    chk(dr_out == C_DEVID, "R1 R7 reset selects device code", dr_out, C_DEVID);
  endtask

  task automatic t_ir_entry();
    for (int i = 0; i < 5; i++) step(1, 0);
    step(0, 0); chk(o_en == 0, "R2 TMS 0 -> idle, no drive", 32'(o_en), 0);
    step(1, 0); step(1, 0); step(0, 0);
    chk(o_en == 0, "R3 capture-IR not driving", 32'(o_en), 0);
    step(0, 0);
    chk(o_en == 1, "R2 0,1,1,0,0 reaches shift-IR", 32'(o_en), 1);
    for (int i = 0; i < 10; i++) step(i == 9, 0);
    chk(o_en == 0, "R3 drive off after exit1-IR", 32'(o_en), 0);
    step(1, 0); step(0, 0);
  endtask

  task automatic t_sample();
    load_ir(C_SAMPLE);
    chk(ir_cap == 10'h155, "R4 capture-IR pattern", 32'(ir_cap), 32'h155);
    chk(en_first && en_all && !en_exit, "R3 enable window in shift-IR",
        {29'd0, en_first, en_all, en_exit}, 32'h6);
    chk(mode_upd == 0, "R9 SAMPLE keeps mode low", 32'(mode_upd), 0);
    cap_cnt = 0; upd_cnt = 0; sh_cnt = 0;
    scan_dr(8, 32'h5A);
    chk(dr_out[7:0] == CHAIN_CAP, "R9 chain capture on TDO", 32'(dr_out[7:0]),
        32'(CHAIN_CAP));
    chk(chain == 8'h5A, "R9 chain holds shifted data", 32'(chain), 32'h5A);
    chk(cap_cnt == 1 && upd_cnt == 1 && sh_cnt == 8, "R9 strobe counts",
        32'(cap_cnt*256 + upd_cnt*16 + sh_cnt), 32'h118);
    scan_dr(16, 32'h00A5);
    chk(dr_out[15:0] == 16'hA5C3, "R9 TDI data returns after chain length",
        32'(dr_out[15:0]), 32'hA5C3);
  endtask

  task automatic t_extest();
    load_ir(C_EXTEST);
    chk(mode_exit == 0, "R5 old instruction held in exit1-IR", 32'(mode_exit), 0);
    chk(mode_upd == 1, "R5 R9 EXTEST effective at update-IR", 32'(mode_upd), 1);
    scan_dr(8, 32'h3C);
    chk(dr_out[7:0] == CHAIN_CAP, "R9 EXTEST chain path", 32'(dr_out[7:0]),
        32'(CHAIN_CAP));
  endtask

  task automatic t_bypass(input logic [9:0] op, input string tag);
    load_ir(op);
    chk(mode_upd == 0 && hiz_upd == 0, {tag, " modes low"},
        {30'd0, mode_upd, hiz_upd}, 0);
    cap_cnt = 0; sh_cnt = 0;
    scan_dr(8, 32'hB4);
    chk(dr_out[7:0] == 8'h68, {tag, " one-stage path"}, 32'(dr_out[7:0]), 32'h68);
    chk(cap_cnt == 0 && sh_cnt == 0, {tag, " chain untouched"},
        32'(cap_cnt + sh_cnt), 0);
  endtask

  task automatic t_usercode();
    user_code = 32'h0BAD_F00D;
    load_ir(C_USER);
    scan_dr(32, 32'h0);
    chk(dr_out == 32'h0BAD_F00D, "R8 user code read", dr_out, 32'h0BAD_F00D);
    user_code = 32'h8765_4321;
    scan_dr(32, 32'hFFFF_FFFF);
    chk(dr_out == 32'h8765_4321, "R8 user code re-captured", dr_out, 32'h8765_4321);
  endtask

  task automatic t_clamp();
    load_ir(C_CLAMP);
    chk(mode_upd == 1 && hiz_upd == 0, "R10 CLAMP mode high, hiz low",
        {30'd0, mode_upd, hiz_upd}, 2);
    cap_cnt = 0; sh_cnt = 0; upd_cnt = 0;
    scan_dr(8, 32'hB4);
    chk(dr_out[7:0] == 8'h68, "R10 CLAMP via bypass", 32'(dr_out[7:0]), 32'h68);
    chk(cap_cnt + sh_cnt + upd_cnt == 0, "R10 CLAMP chain silent",
        32'(cap_cnt + sh_cnt + upd_cnt), 0);
  endtask

  task automatic t_highz();
    load_ir(C_HIGHZ);
    chk(hiz_upd == 1, "R11 HIGHZ sets hiz", 32'(hiz_upd), 1);
    cap_cnt = 0; sh_cnt = 0;
    scan_dr(8, 32'hB4);
    chk(dr_out[7:0] == 8'h68 && cap_cnt + sh_cnt == 0, "R11 HIGHZ via bypass",
        32'(dr_out[7:0]), 32'h68);
    chk(chain_hiz == 1, "R11 hiz held across scan", 32'(chain_hiz), 1);
  endtask

  task automatic t_forced_reset();
    // HIGHZ is current. Enter shift-DR, four highs then 0,0: shift-IR, not reset
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 4; i++) step(1, 0);
    step(0, 0); step(0, 0);
    chk(o_en == 1, "R1 four highs do not reset", 32'(o_en), 1);
    for (int i = 0; i < 5; i++) step(1, 0);
    chk(chain_hiz == 0 && chain_mode == 0, "R1 R12 five highs reset",
        {30'd0, chain_mode, chain_hiz}, 0);
    step(1, 0); step(1, 0);
    chk(chain_hiz == 0, "R1 stays in reset with TMS high", 32'(chain_hiz), 0);
    step(0, 0);
    scan_dr(32, 32'h0);
    chk(dr_out == C_DEVID, "R5 reset loads IDCODE", dr_out, C_DEVID);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge tck);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    @(negedge tck); #2;
    t_reset_state();
    t_ir_entry();
    t_sample();
    t_extest();
    t_bypass(C_ONES, "R6 all-ones");
    t_bypass(C_ODD, "R6 unknown opcode");
    t_usercode();
    t_clamp();
    t_highz();
    t_forced_reset();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule